// File: doc/BRIEF.md
# Sector Write Load-Window Controller

This block sequences writes into one segment of a page-programmed non-volatile memory. Each write strobe is the overlap of an active-low chip enable and an active-low write enable, both sampled on the system clock. A strobe places one byte into a sector-sized staging buffer. No erase step is needed before loading. The byte position and the sector number are taken when the strobe becomes valid. The data is taken when the strobe ends.

The first valid strobe opens a load window. Every later strobe must become valid within a set number of clock cycles after the previous one ended. When that limit runs out, the window closes and the block starts a self-timed programming phase. It pulses a start signal for one cycle, raises busy for a fixed number of cycles and shows the sector being programmed. A recovery phase follows, and reads stay blocked until it ends. Strobes shorter than a filter length are rejected. Buffer positions that were not written in the current window read back as a fixed fill value, which models their indeterminate state.

Top module: `sect_wr_seq`

## Requirements
- R1: After reset, busy and progStart are 0, rdValid is 1 and every buffer position reads the fill value (default 8'hFF).
- R2: A strobe is the cycles in which ceN and weN are both 0. If a strobe lasts fewer than FILT_CYC clock cycles, it captures nothing, loads nothing and does not restart or open a window.
- R3: byteAddr and secAddr are captured at the clock edge where the strobe has been present for FILT_CYC cycles. Later changes to either input during the strobe have no effect.
- R4: dataIn is captured at the first clock edge after ceN or weN returns to 1, whichever rises first. Values of dataIn earlier in the strobe have no effect.
- R5: If no new strobe becomes valid within TIMEOUT_CYC clock edges after the edge that ended the last strobe, progStart is 1 for exactly one cycle, starting right after that TIMEOUT_CYC-th edge.
- R6: If a strobe becomes valid at the same edge where the window would expire, the strobe wins and the window stays open. One cycle later, the strobe would arrive too late.
- R7: busy rises together with progStart and stays 1 for exactly PROG_CYC cycles.
- R8: progSector shows the sector captured at the last valid strobe of the window, from the progStart cycle until the end of busy.
- R9: rdData at rdAddr returns the last byte loaded to that position in the current window. Positions not loaded return the fill value. The first valid strobe of a new window forgets everything loaded in earlier windows.
- R10: Strobes during busy or recovery are ignored. They load nothing and open no window.
- R11: rdValid is 0 while busy and for RECOV_CYC cycles after busy falls, then returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| secAddr | input | SECT_W | Sector number of the write |
| byteAddr | input | BYTE_W | Byte position inside the sector |
| dataIn | input | DATA_W | Write data |
| rdAddr | input | BYTE_W | Buffer read position |
| rdData | output | DATA_W | Buffer content or fill value |
| rdValid | output | 1 | Reads may be serviced |
| progStart | output | 1 | One-cycle pulse at window close |
| busy | output | 1 | Programming in progress |
| progSector | output | SECT_W | Sector being programmed |

## Verification
Two events can land on the same clock edge: the window timer expiring, and the next strobe passing the glitch filter. The bench provokes this by choosing the idle gap after a load so that the filtered fall lands exactly on the expiring edge. It expects the window to stay open and later checks that the extra byte was stored. It then widens the gap by one cycle and expects the programming phase to start first. In that case the late byte must be missing from the read-back.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_RECOV
  } swsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;      // take byte position and sector
    logic wrByte;       // write captured position with dataIn
    logic clrMarks;     // forget loads of earlier windows
    logic latchSector;  // freeze sector for programming
  } swsStrobe_t;

endpackage

// File: rtl/sws_ctrl.sv
module sws_ctrl
  import sws_pkg::*;
#(
  parameter int FILT_CYC    = 2,
  parameter int TIMEOUT_CYC = 7500,
  parameter int PROG_CYC    = 500000,
  parameter int RECOV_CYC   = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  output swsStrobe_t strb,
  output logic       progStart,
  output logic       busy,
  output logic       rdValid
);

  localparam int FW      = $clog2(FILT_CYC + 1);
  localparam int TW      = $clog2(TIMEOUT_CYC + 1);
  localparam int PMAX    = (PROG_CYC > RECOV_CYC) ? PROG_CYC : RECOV_CYC;
  localparam int PW      = $clog2(PMAX + 1);
  localparam logic [FW-1:0] FILT_FULL = FW'(FILT_CYC);
  localparam logic [FW-1:0] FILT_PRE  = FW'(FILT_CYC - 1);
  localparam logic [TW-1:0] TO_LAST   = TW'(TIMEOUT_CYC - 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);
  localparam logic [PW-1:0] REC_LAST  = PW'(RECOV_CYC - 1);

  swsState_t     state;
  logic [FW-1:0] lowCnt;
  logic [TW-1:0] idleCnt;
  logic [PW-1:0] phaseCnt;

  logic rawAct, qualAct, fallEvt, relEvt, timeoutHit;

  // glitch filter: overlap must persist FILT_CYC cycles
  assign rawAct  = !ceN && !weN;
  assign qualAct = (lowCnt == FILT_FULL);
  assign fallEvt = rawAct && (lowCnt == FILT_PRE);
  assign relEvt  = !rawAct && qualAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowCnt <= '0;
    else if (!rawAct)   lowCnt <= '0;
    else if (!qualAct)  lowCnt <= lowCnt + 1'b1;
  end

  // a qualifying fall on the last window cycle beats the timeout
  assign timeoutHit = (state == ST_LOAD) && !qualAct && !fallEvt &&
                      (idleCnt == TO_LAST);

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        strb.capAddr  = fallEvt;
        strb.clrMarks = fallEvt;
      end
      ST_LOAD: begin
        strb.capAddr     = fallEvt;
        strb.wrByte      = relEvt;
        strb.latchSector = timeoutHit;
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idleCnt   <= '0;
      phaseCnt  <= '0;
      progStart <= 1'b0;
    end else begin
      progStart <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fallEvt) begin
            state   <= ST_LOAD;
            idleCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (qualAct || fallEvt) begin
            idleCnt <= '0;
          end else if (timeoutHit) begin
            state     <= ST_PROG;
            phaseCnt  <= '0;
            progStart <= 1'b1;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (phaseCnt == PROG_LAST) begin
            state    <= ST_RECOV;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          if (phaseCnt == REC_LAST) begin
            state    <= ST_IDLE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy    = (state == ST_PROG);
  assign rdValid = (state == ST_IDLE) || (state == ST_LOAD);

endmodule

// File: rtl/sws_dpath.sv
module sws_dpath
  import sws_pkg::*;
#(
  parameter int                SECT_W   = 11,
  parameter int                BYTE_W   = 9,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] FILL_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  swsStrobe_t        strb,
  input  logic [SECT_W-1:0] secAddr,
  input  logic [BYTE_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [BYTE_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [SECT_W-1:0] progSector
);

  localparam int DEPTH = 1 << BYTE_W;

  logic [DATA_W-1:0] stage [DEPTH];
  logic              marks [DEPTH];
  logic [BYTE_W-1:0] capByte;
  logic [SECT_W-1:0] capSector;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capByte    <= '0;
      capSector  <= '0;
      progSector <= '0;
    end else begin
      if (strb.capAddr) begin
        capByte   <= byteAddr;
        capSector <= secAddr;
      end
      if (strb.latchSector) progSector <= capSector;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrByte) stage[capByte] <= dataIn;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mark
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         marks[i] <= 1'b0;
      else if (strb.clrMarks)                            marks[i] <= 1'b0;
      else if (strb.wrByte && capByte == BYTE_W'(i))     marks[i] <= 1'b1;
    end
  end

  assign rdData = marks[rdAddr] ? stage[rdAddr] : FILL_VAL;

endmodule

// File: rtl/sect_wr_seq.sv
module sect_wr_seq
  import sws_pkg::*;
#(
  parameter int                SECT_W      = 11,
  parameter int                BYTE_W      = 9,
  parameter int                DATA_W      = 8,
  parameter int                FILT_CYC    = 2,
  parameter int                TIMEOUT_CYC = 7500,
  parameter int                PROG_CYC    = 500000,
  parameter int                RECOV_CYC   = 500000,
  parameter logic [DATA_W-1:0] FILL_VAL    = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [SECT_W-1:0] secAddr,
  input  logic [BYTE_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [BYTE_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              progStart,
  output logic              busy,
  output logic [SECT_W-1:0] progSector
);

  swsStrobe_t strb;

  sws_ctrl #(
    .FILT_CYC   (FILT_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .PROG_CYC   (PROG_CYC),
    .RECOV_CYC  (RECOV_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .weN      (weN),
    .strb     (strb),
    .progStart(progStart),
    .busy     (busy),
    .rdValid  (rdValid)
  );

  sws_dpath #(
    .SECT_W  (SECT_W),
    .BYTE_W  (BYTE_W),
    .DATA_W  (DATA_W),
    .FILL_VAL(FILL_VAL)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .secAddr   (secAddr),
    .byteAddr  (byteAddr),
    .dataIn    (dataIn),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .progSector(progSector)
  );

endmodule

// File: rtl/sws_chk.sv
module sws_chk #(
  parameter int SECT_W   = 11,
  parameter int PROG_CYC = 500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              rdValid,
  input logic              progStart,
  input logic [SECT_W-1:0] progSector
);

  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R11
  no_rd_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !rdValid);

  // R11
  rd_blocked_after_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !rdValid);

  // R5
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  // R7
  busy_with_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> progStart);

  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == 32'(PROG_CYC)));

  // R8
  sector_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !progStart) |-> $stable(progSector));

endmodule

bind sect_wr_seq sws_chk #(
  .SECT_W  (SECT_W),
  .PROG_CYC(PROG_CYC)
) u_sws_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .rdValid   (rdValid),
  .progStart (progStart),
  .progSector(progSector)
);

// File: tb/sect_wr_seq_bench.sv
module sect_wr_seq_bench;

  localparam int SW = 11, BW = 9, DW = 8;
  localparam int FILT = 2, TO = 20, PROG = 30, RECOV = 15;
  localparam int DEPTH = 1 << BW;

  logic          clk = 1'b0;
  logic          rstN, ceN, weN;
  logic [SW-1:0] secAddr, progSector;
  logic [BW-1:0] byteAddr, rdAddr;
  logic [DW-1:0] dataIn, rdData;
  logic          rdValid, progStart, busy;

  always #10 clk = ~clk;

  sect_wr_seq #(
    .SECT_W(SW), .BYTE_W(BW), .DATA_W(DW), .FILT_CYC(FILT),
    .TIMEOUT_CYC(TO), .PROG_CYC(PROG), .RECOV_CYC(RECOV), .FILL_VAL(8'hFF)
  ) u_sect_wr_seq (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .secAddr(secAddr),
    .byteAddr(byteAddr), .dataIn(dataIn), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid), .progStart(progStart), .busy(busy), .progSector(progSector)
  );

  int  checks = 0, errors = 0;
  bit  done = 0;
  logic [DW-1:0] expData [DEPTH];
  bit            expMark [DEPTH];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expRead(input int a);
    return expMark[a] ? expData[a] : 8'hFF;
  endfunction

  function automatic void startWindow();
    for (int a = 0; a < DEPTH; a++) expMark[a] = 0;
  endfunction

  // entered and left at a negedge with no strobe present
  task automatic doWrite(input logic [SW-1:0] sec, input int ba, input logic [DW-1:0] d,
                         input int gap, input int hold, input bit ceFirst,
                         input bit weRiseFirst, input bit model);
    repeat (gap) @(negedge clk);
    dataIn = DW'($urandom); byteAddr = BW'($urandom);
    if (ceFirst) ceN = 1'b0; else weN = 1'b0;
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; byteAddr = BW'(ba); secAddr = sec;
    repeat (FILT) @(negedge clk);
    byteAddr = BW'($urandom); secAddr = SW'($urandom);   // R3: late changes ignored
    repeat (hold) @(negedge clk);
    dataIn = d;                                          // R4: only value at release counts
    if (weRiseFirst) weN = 1'b1; else ceN = 1'b1;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; dataIn = DW'($urandom);
    if (model) begin expData[ba] = d; expMark[ba] = 1; end
  endtask

  task automatic glitch(input int ba, input logic [DW-1:0] d);
    ceN = 1'b0; weN = 1'b0; byteAddr = BW'(ba); dataIn = d;
    repeat (FILT - 1) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
  endtask

  // entered one negedge after the release edge of the last load
  task automatic waitProgram(input logic [SW-1:0] expSec, input bit intrude, input int ia);
    for (int i = 2; i <= TO + PROG + RECOV + 1; i++) begin
      @(negedge clk);
      if (intrude) begin
        if (i == TO + 3 || i == TO + PROG + 2) begin   // R10 strobes in busy and recovery
          ceN = 1'b0; weN = 1'b0; byteAddr = BW'(ia); secAddr = ~expSec;
          dataIn = ~expRead(ia);
        end
        if (i == TO + 3 + FILT + 2 || i == TO + PROG + 2 + FILT + 2) begin
          ceN = 1'b1; weN = 1'b1;
        end
      end
      if (i == TO)     chk(!progStart && !busy, "R5", "early start", progStart, 0);
      if (i == TO + 1) begin
        chk(progStart && busy, "R5", "start pulse", {progStart, busy}, 3);
        chk(progSector == expSec, "R8", "sector", progSector, expSec);
      end
      if (i == TO + 2) chk(!progStart && busy, "R5", "pulse width", progStart, 0);
      if (i == TO + PROG) chk(busy && !rdValid, "R7", "busy end", {busy, rdValid}, 2);
      if (i == TO + PROG + 1) chk(!busy && !rdValid, "R7", "busy fall", {busy, rdValid}, 0);
      if (i == TO + PROG + RECOV) chk(!rdValid, "R11", "recovery", rdValid, 0);
      if (i == TO + PROG + RECOV + 1) chk(rdValid && !busy, "R11", "read ready", rdValid, 1);
    end
  endtask

  task automatic noProgram(input string req, input int cyc);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (busy || progStart) seen = 1;
    end
    chk(!seen, req, "unexpected program", seen, 0);
  endtask

  task automatic readback(input string req);
    int bad = 0, firstA = -1;
    logic [DW-1:0] firstV;
    for (int a = 0; a < DEPTH; a++) begin
      rdAddr = BW'(a);
      #1;
      if (rdData !== expRead(a)) begin
        bad++;
        if (firstA < 0) begin firstA = a; firstV = rdData; end
      end
    end
    if (firstA >= 0) chk(0, req, $sformatf("read addr %0d", firstA), firstV, expRead(firstA));
    else             chk(1, req, "read", 0, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int a = 0; a < DEPTH; a++) begin expMark[a] = 0; expData[a] = '0; end
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; secAddr = '0; byteAddr = '0;
    dataIn = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !progStart && rdValid, "R1", "reset outputs", {busy, progStart, rdValid}, 1);
    rstN = 1'b1;
    @(negedge clk);
    readback("R1");

    // directed window with a glitch in the middle
    startWindow();
    doWrite(11'h155, 0,   8'h11, 0, 0, 1, 1, 1);
    doWrite(11'h155, 511, 8'h22, 2, 1, 0, 0, 1);
    doWrite(11'h155, 5,   8'h33, 0, 2, 1, 0, 1);
    glitch(5, 8'h99);                                  // R2
    doWrite(11'h155, 7,   8'h44, 1, 0, 0, 1, 1);
    waitProgram(11'h155, 1, 7);
    readback("R2");
    noProgram("R10", TO + 5);
    readback("R10");

    // R6: filtered fall lands on the expiring edge
    startWindow();
    doWrite(11'h2AA, 40, 8'hA1, 0, 0, 1, 1, 1);
    doWrite(11'h2AB, 41, 8'hA2, TO - FILT - 1, 0, 1, 1, 1);
    chk(!busy && !progStart, "R6", "window extended", busy, 0);
    waitProgram(11'h2AB, 0, 0);
    readback("R9");                                    // older window forgotten

    // R6: one cycle later the strobe is too late
    startWindow();
    doWrite(11'h033, 100, 8'h5A, 0, 0, 1, 1, 1);
    doWrite(11'h034, 101, 8'hA5, TO - FILT, 0, 1, 1, 0);
    chk(busy, "R6", "late strobe after start", busy, 1);
    chk(progSector == 11'h033, "R8", "sector late case", progSector, 11'h033);
    for (int k = 0; k < 200 && !rdValid; k++) @(negedge clk);
    readback("R6");

    // R2: glitch alone in idle opens no window
    glitch(200, 8'h77);
    noProgram("R2", TO + 8);
    readback("R2");

    // constrained random windows
    for (int w = 0; w < 10; w++) begin
      logic [SW-1:0] sec;
      int n;
      sec = SW'($urandom);
      n = 1 + ($urandom % 8);
      startWindow();
      for (int k = 0; k < n; k++) begin
        int ba;
        ba = (k > 0 && ($urandom % 4 == 0)) ? 7 : int'($urandom % DEPTH);  // repeats: last wins
        doWrite(sec, ba, DW'($urandom), $urandom % 7, $urandom % 3,
                1'($urandom), 1'($urandom), 1);
      end
      waitProgram(sec, 1'($urandom), $urandom % DEPTH);
      readback("R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule